// File: doc/BRIEF.md
# Switch-Addressed 32-Bit Parallel Output Port

This block is the write side of a simple I/O card on an 8-bit ISA-style expansion bus. It exposes four byte-wide output registers which together form one 32-bit parallel output. A host write to any of four consecutive I/O addresses updates one of those bytes. The other three bytes are left as they were.

The port's location in I/O space is not fixed. An external switch bank supplies the upper address bits, and a write is taken only when bits 19..2 of the bus address equal that switch value. Address bits 1..0 pick the byte lane. Writes that happen during DMA cycles, when AEN is high, are discarded. The active-low write strobe is brought into the block clock domain through a synchroniser. The data byte is committed on the strobe's trailing, rising edge, using the bus values present while the strobe was low. Each byte lane has its own enable. When a lane is disabled it drives zero, but the stored value is kept.

Top module: `isa_outport`

## Requirements
- R1: Reset sets all four stored bytes to zero. With every lane enabled, `port_q` then reads 32'h0000_0000.
- R2: An accepted write stores `bus_data` into lane `bus_addr[1:0]`. Lane k appears on `port_q[8k+7:8k]`.
- R3: A write is accepted only when `bus_addr[19:2]` equals `base_sw`.
- R4: A write whose `bus_addr[19:2]` differs from `base_sw` changes no stored byte.
- R5: A write made while `bus_aen` is 1 changes no stored byte.
- R6: Nothing is stored while `bus_iow_n` is held low. The byte is stored only after `bus_iow_n` returns high, within six clock cycles of that rising edge.
- R7: When `out_en[k]` is 0, lane k of `port_q` reads zero. The stored byte is kept and reappears once `out_en[k]` returns to 1.
- R8: A change of `base_sw` at run time moves the port. The new address range is accepted and the old one is ignored.
- R9: A write to one lane leaves the other three lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | I/O address bus |
| bus_data | input | 8 | Write data bus |
| bus_aen | input | 1 | High during DMA cycles; a write seen with it high is discarded |
| bus_iow_n | input | 1 | Active-low I/O write strobe, asynchronous to clk |
| base_sw | input | 18 | Switch-set base, compared with address bits 19..2 |
| out_en | input | 4 | Per-lane output enable, active high |
| port_q | output | 32 | Gated 32-bit parallel output |

## Verification
The bench targets several corner cases, and each catches a specific design fault. An address that differs from the base only in bit 19 or bit 10 exposes a decoder that compares too few bits: such a design would overwrite a lane. A write made with AEN high checks the DMA qualifier: a design that ignores it stores the byte. A long strobe is sampled while still low, which catches a design that stores on the falling edge, because the lane would already show the new byte. Turning a lane's enable off and on again shows whether gating is applied after the register or wrongly clears the stored value. Moving the switch base checks that the old address range stops responding.

// File: rtl/isa_outport_pkg.sv
package isa_outport_pkg;
    parameter int ADDR_W    = 20;
    parameter int DATA_W    = 8;
    parameter int NUM_LANES = 4;
    parameter int SEL_W     = $clog2(NUM_LANES);
    parameter int BASE_W    = ADDR_W - SEL_W;
    parameter int OUT_W     = NUM_LANES * DATA_W;
    parameter int SYNC_LEN  = 2;
endpackage

// File: rtl/isa_strobe_sync.sv
module isa_strobe_sync #(
    parameter int ADDR_W   = isa_outport_pkg::ADDR_W,
    parameter int DATA_W   = isa_outport_pkg::DATA_W,
    parameter int SYNC_LEN = isa_outport_pkg::SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_aen,
    input  logic              bus_iow_n,
    output logic              rise_o,
    output logic [ADDR_W-1:0] snap_addr_o,
    output logic [DATA_W-1:0] snap_data_o,
    output logic              snap_aen_o
);
    typedef struct packed {
        logic [SYNC_LEN-1:0] chain;
        logic                last;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                aen;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic strobe_now;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_LEN-2:0], bus_iow_n};
        strobe_now = st_q.chain[SYNC_LEN-1];
        st_d.last  = strobe_now;
        // Bus values are sampled while the first synchroniser stage shows
        // the strobe low; they are frozen once it has gone high again.
        if (!st_q.chain[0]) begin
            st_d.addr = bus_addr;
            st_d.data = bus_data;
            st_d.aen  = bus_aen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.chain <= '1;
            st_q.last  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o      = strobe_now && !st_q.last;
    assign snap_addr_o = st_q.addr;
    assign snap_data_o = st_q.data;
    assign snap_aen_o  = st_q.aen;

    // R6: the trailing-edge pulse lasts a single cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
    parameter int ADDR_W = isa_outport_pkg::ADDR_W,
    parameter int SEL_W  = isa_outport_pkg::SEL_W,
    parameter int BASE_W = ADDR_W - SEL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base_sw,
    output logic              hit_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic [BASE_W-1:0] bit_eq;

    for (genvar g = 0; g < BASE_W; g++) begin : g_cmp
        assign bit_eq[g] = (addr[SEL_W+g] == base_sw[g]);
    end

    always_comb begin
        hit_o = &bit_eq;
        sel_o = addr[SEL_W-1:0];
    end
endmodule

// File: rtl/isa_byte_regs.sv
module isa_byte_regs #(
    parameter int DATA_W    = isa_outport_pkg::DATA_W,
    parameter int NUM_LANES = isa_outport_pkg::NUM_LANES,
    parameter int SEL_W     = $clog2(NUM_LANES),
    parameter int OUT_W     = NUM_LANES * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_LANES-1:0] out_en,
    output logic [OUT_W-1:0]     port_q
);
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_d, lane_q;
    logic [NUM_LANES-1:0]             lane_we;

    always_comb begin
        lane_d  = lane_q;
        lane_we = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            lane_we[k] = wr_en && (wr_sel == SEL_W'(k));
            if (lane_we[k]) lane_d[k] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_gate
        assign port_q[g*DATA_W +: DATA_W] = out_en[g] ? lane_q[g] : '0;
    end

    // R9: at most one lane is written at a time
    p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_we));
    // R4: without a write request the stored bytes hold
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lane_q));
    // R2: a request lands in the selected lane
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> lane_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/isa_outport.sv
module isa_outport #(
    parameter int ADDR_W    = isa_outport_pkg::ADDR_W,
    parameter int DATA_W    = isa_outport_pkg::DATA_W,
    parameter int NUM_LANES = isa_outport_pkg::NUM_LANES,
    parameter int SEL_W     = $clog2(NUM_LANES),
    parameter int BASE_W    = ADDR_W - SEL_W,
    parameter int OUT_W     = NUM_LANES * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    input  logic                 bus_aen,
    input  logic                 bus_iow_n,
    input  logic [BASE_W-1:0]    base_sw,
    input  logic [NUM_LANES-1:0] out_en,
    output logic [OUT_W-1:0]     port_q
);
    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    logic              rise;
    logic [ADDR_W-1:0] snap_addr;
    logic [DATA_W-1:0] snap_data;
    logic              snap_aen;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    wr_req_t           req_d, req_q;

    isa_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_aen(bus_aen), .bus_iow_n(bus_iow_n),
        .rise_o(rise), .snap_addr_o(snap_addr),
        .snap_data_o(snap_data), .snap_aen_o(snap_aen)
    );

    isa_addr_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_W(BASE_W)) u_match (
        .addr(snap_addr), .base_sw(base_sw), .hit_o(hit), .sel_o(sel)
    );

    always_comb begin
        req_d.en   = rise && hit && !snap_aen;
        req_d.sel  = sel;
        req_d.data = snap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    isa_byte_regs #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_q.en), .wr_sel(req_q.sel), .wr_data(req_q.data),
        .out_en(out_en), .port_q(port_q)
    );

    // R5: an edge from a DMA cycle never yields a request
    p_dma_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && snap_aen) |=> !req_q.en);
    // R3: an edge whose address misses the base never yields a request
    p_miss_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !hit) |=> !req_q.en);
    // R6: requests only follow a trailing strobe edge
    p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> !req_q.en);
endmodule

// File: tb/tb_isa_outport.sv
module tb_isa_outport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_aen = 1'b0;
    logic        bus_iow_n = 1'b1;
    logic [17:0] base_sw = 18'h000C0;
    logic [3:0]  out_en = 4'hF;
    logic [31:0] port_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    isa_outport dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_aen(bus_aen), .bus_iow_n(bus_iow_n), .base_sw(base_sw),
        .out_en(out_en), .port_q(port_q)
    );

    // {addr, data, aen, expected port_q}, base 0x300
    localparam logic [60:0] VEC [10] = '{
        {20'h00300, 8'hA5, 1'b0, 32'h000000A5},   // R2 lane 0
        {20'h00301, 8'h3C, 1'b0, 32'h00003CA5},   // R2 lane 1
        {20'h00302, 8'h7E, 1'b0, 32'h007E3CA5},   // R2 lane 2
        {20'h00303, 8'h81, 1'b0, 32'h817E3CA5},   // R2 lane 3
        {20'h00304, 8'hFF, 1'b0, 32'h817E3CA5},   // R4 next block
        {20'h00302, 8'h11, 1'b1, 32'h817E3CA5},   // R5 DMA cycle
        {20'h00700, 8'h22, 1'b0, 32'h817E3CA5},   // R4 bit 10 differs
        {20'h00301, 8'h00, 1'b0, 32'h817E00A5},   // R9 other lanes kept
        {20'h00303, 8'h5A, 1'b0, 32'h5A7E00A5},   // R3 match accepted
        {20'h80300, 8'h66, 1'b0, 32'h5A7E00A5}    // R4 bit 19 differs
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [7:0] d, input logic aen);
        @(negedge clk);
        bus_addr  = a;
        bus_data  = d;
        bus_aen   = aen;
        bus_iow_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_iow_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", port_q, 32'h0);

        for (int i = 0; i < 10; i++) begin
            bus_write(VEC[i][60:41], VEC[i][40:33], VEC[i][32]);
            check($sformatf("R2/R3/R4/R5/R9 vector %0d", i), port_q, VEC[i][31:0]);
        end

        // R6: long strobe, nothing stored while low
        @(negedge clk);
        bus_addr = 20'h00300; bus_data = 8'hC3; bus_aen = 1'b0; bus_iow_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R6 strobe still low", port_q, 32'h5A7E00A5);
        bus_iow_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R6 stored after release", port_q, 32'h5A7E00C3);

        // R7: gating keeps the stored byte
        out_en = 4'b1011;
        @(negedge clk);
        check("R7 lane 2 gated", port_q, 32'h5A0000C3);
        out_en = 4'b0000;
        @(negedge clk);
        check("R7 all gated", port_q, 32'h0);
        out_en = 4'hF;
        @(negedge clk);
        check("R7 value restored", port_q, 32'h5A7E00C3);

        // R8: move the base to 0x3E0
        base_sw = 18'h000F8;
        bus_write(20'h003E2, 8'h99, 1'b0);
        check("R8 new base accepted", port_q, 32'h5A9900C3);
        bus_write(20'h00300, 8'h44, 1'b0);
        check("R8 old base ignored", port_q, 32'h5A9900C3);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", port_q, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays clear", port_q, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule